// File: doc/BRIEF.md
# Dual-Width Arithmetic and Logic Unit with Condition Flags

This block computes add, subtract, bitwise logic, move and byte sign extension on one 16-bit datapath. A byte-mode select narrows any of these operations, except sign extension, to the low byte of that same datapath. A carry input lets software build wider arithmetic from successive word or byte portions. The result is produced combinationally in the same cycle as the operands.

Four condition flags are held in a small status register: negative, zero, carry and overflow. For subtraction the carry flag means borrow. Because unsigned carry and signed overflow are both provided, a branch unit can test either kind of comparison. The status register loads on a rising clock edge only when the flag-write enable is high. A register write and the operation that produced it share the same cycle.

The adder is split into two chained half-width lanes. In word mode the carry ripples from the low lane into the high lane. In byte mode the flags are read from the low lane, and the upper result byte is taken unchanged from operand A.

Top module: `duo_width_alu`

## Requirements
- R1: Opcode 0 (add) gives result = A + B mod 2^16 and ignores `carry_in`. Opcode 1 (add with carry) gives result = A + B + `carry_in`.
- R2: Opcode 2 (subtract) gives result = A - B. Opcode 3 (subtract with borrow) gives result = A - B - `carry_in`, where `carry_in` is the incoming borrow. Both results are taken mod 2^16.
- R3: After an arithmetic opcode (0 to 3), flag bit 0 (C) holds the carry out of the active width for add, and the borrow for subtract. The borrow is 1 when unsigned A < B + borrow-in.
- R4: After an arithmetic opcode, flag bit 2 (V) holds signed overflow of the active width. For add this is operands of equal sign with a result of the other sign. For subtract this is operands of different sign with a result whose sign differs from A.
- R5: When `byte_mode` = 1 and the opcode is 0 to 7, the operation uses bits 7:0 only. Result bits 15:8 equal A bits 15:8, and N, Z, C and V are derived from the 8-bit lane, with bit 7 as the sign bit.
- R6: Opcodes 4 (AND), 5 (OR), 6 (XOR) and 7 (move, result = B) update N and Z, clear V and leave C unchanged.
- R7: Opcode 8 (sign-extend byte) gives result = A bits 7:0 with bit 7 copied into bits 15:8, whatever `byte_mode` is. It sets N and Z from the 16-bit result, clears V and leaves C unchanged.
- R8: Flag bit 3 (N) is the top bit of the active-width result. Flag bit 1 (Z) is 1 exactly when the active-width result is zero.
- R9: Reset clears all four flags to 0. The flags change only on a rising clock edge with `flag_we` = 1; otherwise they hold.
- R10: Opcodes 9 to 15 are reserved. They give result = A and leave the flags unchanged even with `flag_we` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| op_sel | input | 4 | Operation code, 0 to 8 defined |
| byte_mode | input | 1 | 1 selects 8-bit operation on the low byte |
| carry_in | input | 1 | Carry (add) or borrow (subtract) for chained arithmetic |
| flag_we | input | 1 | Load the flag register on the next rising edge |
| result | output | 16 | Combinational result |
| flags | output | 4 | Registered flags: bit 3 N, bit 2 V, bit 1 Z, bit 0 C |

## Verification
The bench builds the block with its default `DATA_W` of 16, which makes the lane width 8. This lets directed vectors hit the exact boundaries where the byte and word flags diverge. Examples are 0x7F+1 versus 0x7FFF+1, and 0xFF+1 versus 0xFFFF+1. With 16 bits, a two-step 32-bit add can be chained through the carry flag. A sweep of pseudo-random operands over every opcode and both widths exercises the lane carry ripple across all bit positions.

// File: rtl/duo_alu_pkg.sv
package duo_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_MOV = 4'd7,
      OP_SXB = 4'd8
   } alu_op_e;

   localparam int FLAG_W = 4;
   localparam int FL_C   = 0;
   localparam int FL_Z   = 1;
   localparam int FL_V   = 2;
   localparam int FL_N   = 3;
endpackage

// File: rtl/duo_lane_adder.sv
module duo_lane_adder #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W:0] wide;

   always_comb begin
      wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      sum  = wide[W-1:0];
      cout = wide[W];
      ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
   end
endmodule

// File: rtl/duo_logic_unit.sv
module duo_logic_unit
   import duo_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   op,
   output logic [W-1:0] y
);
   always_comb begin
      case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = b;
      endcase
   end
endmodule

// File: rtl/duo_flag_reg.sv
module duo_flag_reg #(
   parameter int          W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= d;
   end
endmodule

// File: rtl/duo_width_alu.sv
module duo_width_alu
   import duo_alu_pkg::*;
#(
   parameter int               DATA_W    = 16,
   parameter logic [FLAG_W-1:0] FLAG_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [3:0]        op_sel,
   input  logic              byte_mode,
   input  logic              carry_in,
   input  logic              flag_we,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags
);
   localparam int LANE_W = DATA_W / 2;
   localparam int NLANES = 2;

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
         $error("duo_width_alu: DATA_W must be even and at least 4");
      end
   endgenerate

   logic              op_valid, is_arith, is_sub, is_sxb, narrow;
   logic              lane0_cin;
   logic [DATA_W-1:0] b_eff, arith_y, logic_y, sxb_y, core_y;
   logic [NLANES-1:0] lane_cout, lane_ovf;
   logic              c_sel, v_sel;
   logic [FLAG_W-1:0] flags_nxt;

   always_comb begin
      op_valid = (op_sel <= OP_SXB);
      is_arith = (op_sel == OP_ADD) || (op_sel == OP_ADC) ||
                 (op_sel == OP_SUB) || (op_sel == OP_SBC);
      is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBC);
      is_sxb   = (op_sel == OP_SXB);
      narrow   = byte_mode && !is_sxb;
      b_eff    = is_sub ? ~opnd_b : opnd_b;
      case (op_sel)
         OP_ADC:  lane0_cin = carry_in;
         OP_SUB:  lane0_cin = 1'b1;
         OP_SBC:  lane0_cin = ~carry_in;
         default: lane0_cin = 1'b0;
      endcase
   end

   // Two chained lanes; the high lane is only meaningful in word mode.
   generate
      for (genvar g = 0; g < NLANES; g++) begin : g_lane
         logic lane_ci;
         if (g == 0) begin : g_first
            assign lane_ci = lane0_cin;
         end else begin : g_chain
            assign lane_ci = lane_cout[g-1];
         end
         duo_lane_adder #(.W(LANE_W)) u_add (
            .a    (opnd_a[g*LANE_W +: LANE_W]),
            .b    (b_eff[g*LANE_W +: LANE_W]),
            .cin  (lane_ci),
            .sum  (arith_y[g*LANE_W +: LANE_W]),
            .cout (lane_cout[g]),
            .ovf  (lane_ovf[g])
         );
      end
   endgenerate

   duo_logic_unit #(.W(DATA_W)) u_logic (
      .a  (opnd_a),
      .b  (opnd_b),
      .op (op_sel),
      .y  (logic_y)
   );

   always_comb begin
      sxb_y  = {{(DATA_W-LANE_W){opnd_a[LANE_W-1]}}, opnd_a[LANE_W-1:0]};
      core_y = is_arith ? arith_y : logic_y;
      if (!op_valid)   result = opnd_a;
      else if (is_sxb) result = sxb_y;
      else if (narrow) result = {opnd_a[DATA_W-1:LANE_W], core_y[LANE_W-1:0]};
      else             result = core_y;
   end

   always_comb begin
      c_sel = narrow ? lane_cout[0] : lane_cout[NLANES-1];
      v_sel = narrow ? lane_ovf[0]  : lane_ovf[NLANES-1];
      flags_nxt[FL_N] = narrow ? result[LANE_W-1] : result[DATA_W-1];
      flags_nxt[FL_Z] = narrow ? (result[LANE_W-1:0] == '0) : (result == '0);
      flags_nxt[FL_C] = is_arith ? (c_sel ^ is_sub) : flags[FL_C];
      flags_nxt[FL_V] = is_arith ? v_sel : 1'b0;
   end

   duo_flag_reg #(.W(FLAG_W), .RST_VAL(FLAG_RST)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (flag_we && op_valid),
      .d     (flags_nxt),
      .q     (flags)
   );
endmodule

// File: rtl/duo_width_alu_chk.sv
module duo_width_alu_chk
   import duo_alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] opnd_a,
   input logic [3:0]        op_sel,
   input logic              byte_mode,
   input logic              flag_we,
   input logic [DATA_W-1:0] result,
   input logic [FLAG_W-1:0] flags
);
   localparam int LANE_W = DATA_W / 2;

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> $stable(flags)); // R9
   AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > OP_SXB) |-> (result == opnd_a)); // R10
   AST_RESERVED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > OP_SXB) |=> $stable(flags)); // R10
   AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mode && op_sel < OP_SXB) |->
      (result[DATA_W-1:LANE_W] == opnd_a[DATA_W-1:LANE_W])); // R5
   AST_SXB_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_SXB) |->
      (result == {{(DATA_W-LANE_W){opnd_a[LANE_W-1]}}, opnd_a[LANE_W-1:0]})); // R7
   AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel >= OP_AND && op_sel <= OP_SXB) |=>
      (flags[FL_C] == $past(flags[FL_C]) && !flags[FL_V])); // R6
   AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && !byte_mode && op_sel <= OP_SXB) |=>
      (flags[FL_Z] == ($past(result) == '0))); // R8
endmodule

bind duo_width_alu duo_width_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .opnd_a    (opnd_a),
   .op_sel    (op_sel),
   .byte_mode (byte_mode),
   .flag_we   (flag_we),
   .result    (result),
   .flags     (flags)
);

// File: tb/duo_width_alu_test.sv
module duo_width_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] opnd_a = '0, opnd_b = '0;
   logic [3:0]  op_sel = '0;
   logic        byte_mode = 1'b0, carry_in = 1'b0, flag_we = 1'b0;
   logic [15:0] result;
   logic [3:0]  flags;

   int checks = 0;
   int failures = 0;
   logic [3:0] exp_flags = 4'h0;

   always #2 clk = ~clk;

   duo_width_alu #(.DATA_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .op_sel(op_sel), .byte_mode(byte_mode), .carry_in(carry_in),
      .flag_we(flag_we), .result(result), .flags(flags)
   );

   // Reference model built from the requirements. flags: {N,V,Z,C}
   function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                 input logic [3:0] op, input logic bm,
                                 input logic ci, input logic [3:0] fin,
                                 output logic [15:0] r, output logic [3:0] fo);
      int w;
      longint am, bv, s, msk;
      logic [31:0] rr;
      logic sa, sb, sr, c, v;
      w   = (bm && op != 4'd8) ? 8 : 16;
      msk = (longint'(1) << w) - 1;
      am  = longint'(a) & msk;
      bv  = longint'(b) & msk;
      fo  = fin;
      c   = fin[0];
      v   = 1'b0;
      s   = 0;
      case (op)
         4'd0: s = am + bv;
         4'd1: s = am + bv + longint'(ci);
         4'd2: s = am - bv;
         4'd3: s = am - bv - longint'(ci);
         4'd4: s = am & bv;
         4'd5: s = am | bv;
         4'd6: s = am ^ bv;
         4'd7: s = bv;
         4'd8: s = longint'({{8{a[7]}}, a[7:0]});
         default: s = longint'(a);
      endcase
      rr = 32'(s & msk);
      sa = am[w-1]; sb = bv[w-1]; sr = rr[w-1];
      if (op <= 4'd1) begin
         c = ((s >> w) & 1) != 0;
         v = (sa == sb) && (sr != sa);
      end else if (op <= 4'd3) begin
         c = (s < 0);
         v = (sa != sb) && (sr != sa);
      end
      if (op > 4'd8) r = a;
      else if (w == 8) r = {a[15:8], rr[7:0]};
      else r = rr[15:0];
      if (op <= 4'd8) fo = {sr, v, (rr == 0), c};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic [3:0] op, input logic bm, input logic ci,
                        input logic we);
      logic [15:0] er;
      logic [3:0]  ef;
      @(negedge clk);
      opnd_a = a; opnd_b = b; op_sel = op; byte_mode = bm;
      carry_in = ci; flag_we = we;
      model(a, b, op, bm, ci, exp_flags, er, ef);
      #1;
      check(req, "result", result, er);
      @(posedge clk);
      if (we) exp_flags = ef;
      @(negedge clk);
      flag_we = 1'b0;
      check(req, "flags", {12'h0, flags}, {12'h0, exp_flags});
   endtask

   task automatic t_reset();
      #1;
      check("R9", "flags in reset", {12'h0, flags}, 16'h0000);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      check("R9", "flags after reset", {12'h0, flags}, 16'h0000);
   endtask

   task automatic t_word_add();
      apply("R1", 16'h1234, 16'h1111, 4'd0, 1'b0, 1'b1, 1'b1); // cin ignored
      check("R1", "add ignores cin", result, 16'h2345);
      apply("R4", 16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b0, 1'b1);
      check("R4", "V set", {15'h0, flags[2]}, 16'h1);
      apply("R3", 16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b0, 1'b1);
      check("R3", "carry/zero", {12'h0, flags}, 16'h0003);
      apply("R1", 16'h0001, 16'h0001, 4'd1, 1'b0, 1'b1, 1'b1);
      check("R1", "adc", result, 16'h0003);
   endtask

   task automatic t_word_sub();
      apply("R2", 16'h0005, 16'h0007, 4'd2, 1'b0, 1'b0, 1'b1);
      check("R3", "borrow+N", {12'h0, flags}, 16'h0009);
      apply("R4", 16'h8000, 16'h0001, 4'd2, 1'b0, 1'b0, 1'b1);
      check("R4", "sub V", {12'h0, flags}, 16'h0004);
      apply("R2", 16'h0005, 16'h0003, 4'd3, 1'b0, 1'b1, 1'b1);
      check("R2", "sbc", result, 16'h0001);
      apply("R3", 16'h0003, 16'h0003, 4'd3, 1'b0, 1'b1, 1'b1);
      check("R3", "sbc borrow", {12'h0, flags}, 16'h0009);
   endtask

   task automatic t_byte();
      apply("R5", 16'h12FF, 16'hAB01, 4'd0, 1'b1, 1'b0, 1'b1);
      check("R5", "byte result", result, 16'h1200);
      check("R5", "byte C Z", {12'h0, flags}, 16'h0003);
      apply("R5", 16'h007F, 16'h0001, 4'd0, 1'b1, 1'b0, 1'b1);
      check("R5", "byte V N", {12'h0, flags}, 16'h000C);
      apply("R5", 16'h5500, 16'h0001, 4'd2, 1'b1, 1'b0, 1'b1);
      check("R5", "byte borrow", result, 16'h55FF);
   endtask

   task automatic t_logic();
      apply("R6", 16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b0, 1'b1); // V=1, C=0
      apply("R6", 16'hF0F0, 16'h8F00, 4'd4, 1'b0, 1'b0, 1'b1);
      check("R6", "and clears V", {12'h0, flags}, 16'h0008);
      apply("R6", 16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b0, 1'b1); // C=1
      apply("R6", 16'h1234, 16'h0000, 4'd7, 1'b0, 1'b0, 1'b1);
      check("R6", "mov keeps C", {12'h0, flags}, 16'h0003);
      apply("R6", 16'h00F0, 16'h0F0F, 4'd5, 1'b0, 1'b0, 1'b1);
      apply("R6", 16'hAAAA, 16'hAAAA, 4'd6, 1'b1, 1'b0, 1'b1);
      check("R8", "byte xor zero", {12'h0, flags}, 16'h0003);
   endtask

   task automatic t_sxb();
      apply("R7", 16'h3480, 16'h0000, 4'd8, 1'b1, 1'b0, 1'b1);
      check("R7", "sxb neg", result, 16'hFF80);
      apply("R7", 16'hAB7F, 16'h0000, 4'd8, 1'b0, 1'b0, 1'b1);
      check("R7", "sxb pos", result, 16'h007F);
   endtask

   task automatic t_chain();
      logic [15:0] lo;
      apply("R1", 16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b0, 1'b1);
      lo = result;
      apply("R1", 16'h0001, 16'h0001, 4'd1, 1'b0, flags[0], 1'b1);
      check("R1", "32-bit chain", {result[7:0], lo[15:8]}, 16'h0300);
   endtask

   task automatic t_hold();
      apply("R9", 16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b0, 1'b1);
      apply("R9", 16'h0000, 16'h0000, 4'd2, 1'b0, 1'b0, 1'b0);
      check("R9", "hold without we", {12'h0, flags}, 16'h000C);
   endtask

   task automatic t_reserved();
      for (int k = 9; k < 16; k++)
         apply("R10", 16'hC3A5, 16'h0000, 4'(k), k[0], 1'b1, 1'b1);
      check("R10", "reserved flags", {12'h0, flags}, 16'h000C);
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 300; i++)
         apply("R8", 16'($urandom), 16'($urandom), 4'(i % 9),
               1'((i / 9) % 2), 1'($urandom), 1'(i % 5 != 0));
   endtask

   initial begin
      void'($urandom(32'h5eed));
      t_reset();
      t_word_add();
      t_word_sub();
      t_byte();
      t_logic();
      t_sxb();
      t_chain();
      t_hold();
      t_reserved();
      t_sweep();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule